// File: doc/BRIEF.md
# Burst Column and Latency Sequencer

This block sits behind a synchronous memory's command decoder. It holds the operating mode: burst length, column ordering, read latency and a single-word-write option. For every read or write command it produces the column to access in each cycle. A write strobe is produced per byte lane. A read-data-valid flag is delayed by the programmed latency, and per-byte output enables follow the byte masks.

A read or write command supplies the first column in its own cycle. The following columns come out one per cycle. They run either in increasing order, wrapping inside the aligned block of the burst size, or in XOR order against the start column. A full-page mode walks every column of the row. Any new read or write restarts the sequence. A terminate or precharge stops column generation. Read data already issued still drains through the latency pipe.

Top module: `burst_seq`

## Requirements
- R1: A mode set command with a legal code takes effect from the next command. The code is mode_data_i[2:0] burst length (000=1, 001=2, 010=4, 011=8, 111=full page), [3] order (0 increasing, 1 XOR), [6:4] latency (010=2, 011=3), [8:7] zero, and [9] single-word writes.
- R2: A mode set whose code is reserved is rejected and the previous mode stays in force. Reserved codes are: latency other than 010/011, burst length 100..110, bits [8:7] non-zero, XOR order with a length other than 4 or 8, and XOR order with full page.
- R3: In increasing order, beat j of a burst of length L from start s uses column (s & ~(L-1)) | ((s+j) & (L-1)).
- R4: In XOR order, beat j uses column (s & ~(L-1)) | ((s^j) & (L-1)), for L of 4 or 8.
- R5: A full-page burst gives 256 beats of (s+j) mod 256.
- R6: A write's first beat is in the command cycle. wr_stb_o[b] is high on each write beat unless mask_i[b] is high in that same cycle.
- R7: Each read beat raises rd_vld_o exactly latency cycles after the beat's cycle.
- R8: A read or write command during a burst restarts the sequence from its own column in its own cycle.
- R9: A terminate or precharge during a read ends column beats in its own cycle. Read data issued before it still appears after the latency.
- R10: A terminate during a write drops wr_stb_o and col_vld_o in its own cycle and after.
- R11: While rd_vld_o is high, oe_o[b] equals the inverse of mask_i[b] from two cycles earlier.
- R12: rd_vld_o is forced low two cycles after any write command.
- R13: With mode bit [9] set, writes last one beat and reads keep the programmed length.
- R14: After reset all outputs are low. The mode is then length 1, increasing order, latency 2, with bursting writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Load mode from mode_data_i |
| mode_data_i | input | 10 | Mode code |
| rd_i | input | 1 | Read command |
| wr_i | input | 1 | Write command (wins over rd_i) |
| term_i | input | 1 | Burst terminate |
| pre_i | input | 1 | Precharge (ends burst) |
| col_i | input | COL_W | Start column |
| mask_i | input | NB | Per-byte mask |
| col_o | output | COL_W | Column of the current beat |
| col_vld_o | output | 1 | A beat is issued this cycle |
| wr_stb_o | output | NB | Per-byte write strobe |
| rd_vld_o | output | 1 | Read data valid |
| oe_o | output | NB | Per-byte output enable |

## Verification
Two functions can land in the same cycle. One is a read datum leaving the latency pipe. The other is the automatic output disable caused by a write command two cycles earlier. The bench issues a four-beat read at latency 3 and follows it after two cycles with a write. It then expects exactly one valid read cycle while the write beats proceed. A second collision pairs a byte mask with a read datum in flight. The bench expects only that datum's enables to drop, two cycles after the mask.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int MODE_W = 10;
  localparam logic [2:0] LAT_2 = 3'b010;
  localparam logic [2:0] LAT_3 = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] lat;
    logic       ilv;
    logic [2:0] bl;
  } mode_t;

  function automatic logic mode_ok(input logic [MODE_W-1:0] d);
    logic lat_ok, len_ok;
    lat_ok = (d[6:4] == LAT_2) || (d[6:4] == LAT_3);
    if (d[3]) len_ok = (d[2:0] == 3'b010) || (d[2:0] == 3'b011);
    else      len_ok = (d[2:0] <= 3'b011) || (d[2:0] == LEN_PAGE);
    return lat_ok && len_ok && (d[8:7] == 2'b00);
  endfunction

  function automatic mode_t unpack_mode(input logic [MODE_W-1:0] d);
    mode_t m;
    m.wr_single = d[9];
    m.lat       = d[5:4];
    m.ilv       = d[3];
    m.bl        = d[2:0];
    return m;
  endfunction
endpackage

// File: rtl/bs_mode_reg.sv
module bs_mode_reg
  import burst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [MODE_W-1:0] data_i,
  output mode_t             mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '{wr_single: 1'b0, lat: 2'b10, ilv: 1'b0, bl: 3'b000};
    end else if (set_i && mode_ok(data_i)) begin
      mode_o <= unpack_mode(data_i);
    end
  end
endmodule

// File: rtl/bs_col_gen.sv
module bs_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       bl_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_o,
  output logic             beat_wr_o
);
  logic             active_q, ilv_q, is_wr_q;
  logic [COL_W-1:0] base_q, cnt_q, lm_q;
  logic [COL_W-1:0] len_m, cmd_m, step, gen_col;
  logic             cmd;

  assign cmd = rd_i | wr_i;

  // wrap mask = burst length - 1
  always_comb begin
    case (bl_i)
      3'd0:    len_m = '0;
      3'd1:    len_m = COL_W'(1);
      3'd2:    len_m = COL_W'(3);
      3'd3:    len_m = COL_W'(7);
      default: len_m = '1;
    endcase
  end

  assign cmd_m   = (wr_i && wr_single_i) ? '0 : len_m;
  assign step    = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign gen_col = (base_q & ~lm_q) | (step & lm_q);

  always_comb begin
    col_o     = '0;
    beat_o    = 1'b0;
    beat_wr_o = 1'b0;
    if (cmd) begin
      col_o     = col_i;
      beat_o    = 1'b1;
      beat_wr_o = wr_i;
    end else if (active_q && !stop_i) begin
      col_o     = gen_col;
      beat_o    = 1'b1;
      beat_wr_o = is_wr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ilv_q    <= 1'b0;
      is_wr_q  <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      lm_q     <= '0;
    end else if (cmd) begin
      active_q <= (cmd_m != '0);
      ilv_q    <= ilv_i;
      is_wr_q  <= wr_i;
      base_q   <= col_i;
      cnt_q    <= COL_W'(1);
      lm_q     <= cmd_m;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + COL_W'(1);
      if (cnt_q == lm_q) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bs_lat_pipe.sv
module bs_lat_pipe #(
  parameter int NB      = 4,
  parameter int MAX_LAT = 3,
  localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             rd_beat_i,
  input  logic             wr_cmd_i,
  input  logic [NB-1:0]    mask_i,
  output logic             rd_vld_o,
  output logic [NB-1:0]    oe_o
);
  localparam int MASK_LAT = 2;

  logic [MAX_LAT-1:0]  rd_sr;
  logic [MASK_LAT-1:0] wr_sr;
  logic [NB-1:0]       mask_sr [MASK_LAT];
  logic [LAT_W-1:0]    tap;

  assign tap = lat_i - LAT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sr <= '0;
      wr_sr <= '0;
    end else begin
      rd_sr <= {rd_sr[MAX_LAT-2:0], rd_beat_i};
      wr_sr <= {wr_sr[MASK_LAT-2:0], wr_cmd_i};
    end
  end

  for (genvar s = 0; s < MASK_LAT; s++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_sr[s] <= '0;
      else if (s == 0) mask_sr[s] <= mask_i;
      else             mask_sr[s] <= mask_sr[(s == 0) ? 0 : s-1];
    end
  end

  assign rd_vld_o = rd_sr[tap] & ~wr_sr[MASK_LAT-1];
  assign oe_o     = {NB{rd_vld_o}} & ~mask_sr[MASK_LAT-1];
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int NB      = 4,
  parameter int MAX_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_set_i,
  input  logic [MODE_W-1:0] mode_data_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              term_i,
  input  logic              pre_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [NB-1:0]     mask_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_vld_o,
  output logic [NB-1:0]     wr_stb_o,
  output logic              rd_vld_o,
  output logic [NB-1:0]     oe_o
);
  localparam int LAT_W = $clog2(MAX_LAT + 1);

  mode_t mode_q;
  logic  beat, beat_wr, rd_cmd;

  // write wins over read when both are raised
  assign rd_cmd = rd_i & ~wr_i;

  bs_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mode_set_i),
    .data_i (mode_data_i),
    .mode_o (mode_q)
  );

  bs_col_gen #(.COL_W(COL_W)) u_col (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bl_i        (mode_q.bl),
    .ilv_i       (mode_q.ilv),
    .wr_single_i (mode_q.wr_single),
    .rd_i        (rd_cmd),
    .wr_i        (wr_i),
    .stop_i      (term_i | pre_i),
    .col_i       (col_i),
    .col_o       (col_o),
    .beat_o      (beat),
    .beat_wr_o   (beat_wr)
  );

  bs_lat_pipe #(.NB(NB), .MAX_LAT(MAX_LAT)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lat_i     (LAT_W'(mode_q.lat)),
    .rd_beat_i (beat & ~beat_wr),
    .wr_cmd_i  (wr_i),
    .mask_i    (mask_i),
    .rd_vld_o  (rd_vld_o),
    .oe_o      (oe_o)
  );

  assign col_vld_o = beat;
  assign wr_stb_o  = {NB{beat & beat_wr}} & ~mask_i;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int COL_W = 8,
  parameter int NB    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             wr_i,
  input logic             term_i,
  input logic             pre_i,
  input logic [COL_W-1:0] col_i,
  input logic [NB-1:0]    mask_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_vld_o,
  input logic [NB-1:0]    wr_stb_o,
  input logic             rd_vld_o,
  input logic [NB-1:0]    oe_o
);
  logic          wr_d1, wr_d2;
  logic [NB-1:0] m_d1, m_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_d1 <= 1'b0; wr_d2 <= 1'b0; m_d1 <= '0; m_d2 <= '0;
    end else begin
      wr_d1 <= wr_i; wr_d2 <= wr_d1; m_d1 <= mask_i; m_d2 <= m_d1;
    end
  end

  // R6
  wr_first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (col_vld_o && col_o == col_i && wr_stb_o == ~mask_i));

  // R10
  stop_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((term_i || pre_i) && !rd_i && !wr_i) |-> (!col_vld_o && wr_stb_o == '0));

  // R12
  wr_kills_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d2 |-> !rd_vld_o);

  // R11
  rd_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> (oe_o == ~m_d2));

  // R11
  oe_only_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o != '0) |-> rd_vld_o);

  // R6
  stb_needs_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o != '0) |-> col_vld_o);
endmodule

bind burst_seq burst_seq_chk #(.COL_W(COL_W), .NB(NB)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .term_i    (term_i),
  .pre_i     (pre_i),
  .col_i     (col_i),
  .mask_i    (mask_i),
  .col_o     (col_o),
  .col_vld_o (col_vld_o),
  .wr_stb_o  (wr_stb_o),
  .rd_vld_o  (rd_vld_o),
  .oe_o      (oe_o)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/100ps
module burst_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_set_i = 1'b0;
  logic [9:0] mode_data_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0, term_i = 1'b0, pre_i = 1'b0;
  logic [7:0] col_i = '0;
  logic [3:0] mask_i = '0;
  logic [7:0] col_o;
  logic       col_vld_o, rd_vld_o;
  logic [3:0] wr_stb_o, oe_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  burst_seq uut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_col(int s, int j, int len, bit ilv);
    int lm = len - 1;
    int v = ilv ? (s ^ j) : (s + j);
    return 8'((s & ~lm) | (v & lm));
  endfunction

  function automatic logic [9:0] mcode(int len, bit ilv, int lat, bit ws);
    logic [2:0] b;
    case (len)
      1: b = 3'd0;
      2: b = 3'd1;
      4: b = 3'd2;
      8: b = 3'd3;
      default: b = 3'd7;
    endcase
    return {ws, 2'b00, 3'(lat), ilv, b};
  endfunction

  task automatic cyc(bit rd, bit wr, bit tm, bit pr, logic [7:0] c, logic [3:0] m);
    @(negedge clk_i);
    rd_i = rd; wr_i = wr; term_i = tm; pre_i = pr; col_i = c; mask_i = m;
    #1;
  endtask

  task automatic set_mode(logic [9:0] d);
    @(negedge clk_i);
    rd_i = 0; wr_i = 0; term_i = 0; pre_i = 0; mask_i = 0;
    mode_set_i = 1'b1; mode_data_i = d;
    @(negedge clk_i);
    mode_set_i = 1'b0;
  endtask

  task automatic run_burst(string tag, bit is_wr, int s, int len, bit ilv, int lat);
    for (int j = 0; j < len + lat + 3; j++) begin
      bit rdv;
      cyc((j == 0) && !is_wr, (j == 0) && is_wr, 0, 0, 8'(s), 4'h0);
      chk(tag, "col_vld", col_vld_o, j < len);
      if (j < len) chk(tag, "col", col_o, exp_col(s, j, len, ilv));
      chk(tag, "wr_stb", wr_stb_o, (is_wr && j < len) ? 4'hf : 4'h0);
      rdv = !is_wr && j >= lat && (j - lat) < len;
      chk(tag, "rd_vld", rd_vld_o, rdv);
      chk(tag, "oe", oe_o, rdv ? 4'hf : 4'h0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lens [5] = '{1, 2, 4, 8, 256};
    int starts [3] = '{0, 13, 250};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R14 reset state and default mode
    cyc(0, 0, 0, 0, 0, 0);
    chk("R14", "col_vld", col_vld_o, 0);
    chk("R14", "wr_stb", wr_stb_o, 0);
    chk("R14", "rd_vld", rd_vld_o, 0);
    chk("R14", "oe", oe_o, 0);
    cyc(1, 0, 0, 0, 8'd9, 0);
    chk("R14", "col", col_o, 9);
    chk("R14", "col_vld", col_vld_o, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R14", "len1 col_vld", col_vld_o, 0);
    chk("R14", "lat2 early", rd_vld_o, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R14", "lat2 rd_vld", rd_vld_o, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R14", "rd_vld end", rd_vld_o, 0);

    // R1 R3 R4 R5 R6 R7 sweep
    for (int lat = 2; lat <= 3; lat++)
      for (int ilv = 0; ilv <= 1; ilv++)
        for (int li = 0; li < 5; li++) begin
          int len = lens[li];
          if (ilv == 1 && len != 4 && len != 8) continue;
          for (int si = 0; si < 3; si++)
            for (int op = 0; op <= 1; op++) begin
              string tag;
              tag = (len == 256) ? "R5" : (ilv == 1) ? "R4" : "R3";
              tag = {tag, (op == 1) ? " R6" : " R7 R1"};
              set_mode(mcode(len, 1'(ilv), lat, 1'b0));
              run_burst(tag, 1'(op), starts[si], len, 1'(ilv), lat);
            end
        end

    // R8 read restarted by read
    set_mode(mcode(8, 0, 3, 0));
    for (int j = 0; j <= 14; j++) begin
      cyc(j == 0 || j == 2, 0, 0, 0, (j == 2) ? 8'd16 : 8'd0, 0);
      chk("R8", "col_vld", col_vld_o, j <= 9);
      if (j <= 9) chk("R8", "col", col_o, (j < 2) ? j : 16 + j - 2);
      chk("R8", "rd_vld", rd_vld_o, j >= 3 && j <= 12);
    end

    // R9 terminate during read, latency 2
    set_mode(mcode(8, 0, 2, 0));
    for (int j = 0; j <= 8; j++) begin
      cyc(j == 0, 0, j == 3, 0, 0, 0);
      chk("R9", "term col_vld", col_vld_o, j < 3);
      chk("R9", "term rd_vld", rd_vld_o, j >= 2 && j <= 4);
    end

    // R9 precharge during read, latency 3
    set_mode(mcode(8, 0, 3, 0));
    for (int j = 0; j <= 8; j++) begin
      cyc(j == 0, 0, 0, j == 2, 0, 0);
      chk("R9", "pre col_vld", col_vld_o, j < 2);
      chk("R9", "pre rd_vld", rd_vld_o, j == 3 || j == 4);
    end

    // R10 terminate during write
    set_mode(mcode(4, 0, 2, 0));
    for (int j = 0; j <= 6; j++) begin
      cyc(0, j == 0, j == 2, 0, 8'd4, 0);
      chk("R10", "wr_stb", wr_stb_o, (j < 2) ? 4'hf : 4'h0);
      chk("R10", "col_vld", col_vld_o, j < 2);
      if (j < 2) chk("R10", "col", col_o, 4 + j);
    end

    // R12 R8 read interrupted by write
    set_mode(mcode(4, 0, 3, 0));
    for (int j = 0; j <= 9; j++) begin
      cyc(j == 0, j == 2, 0, 0, (j == 2) ? 8'd8 : 8'd0, 0);
      chk("R12", "rd_vld", rd_vld_o, j == 3);
      chk("R8", "wr_stb", wr_stb_o, (j >= 2 && j <= 5) ? 4'hf : 4'h0);
      chk("R8", "col_vld", col_vld_o, j <= 5);
      if (j <= 5) chk("R8", "col", col_o, (j < 2) ? j : 8 + j - 2);
    end

    // R11 read mask two cycles later
    set_mode(mcode(4, 0, 2, 0));
    for (int j = 0; j <= 7; j++) begin
      bit rdv;
      cyc(j == 0, 0, 0, 0, 0, (j == 1) ? 4'h3 : 4'h0);
      rdv = j >= 2 && j <= 5;
      chk("R11", "rd_vld", rd_vld_o, rdv);
      chk("R11", "oe", oe_o, rdv ? ((j == 3) ? 4'hc : 4'hf) : 4'h0);
    end

    // R6 write mask same cycle
    for (int j = 0; j <= 4; j++) begin
      cyc(0, j == 0, 0, 0, 0, (j == 0) ? 4'h5 : (j == 1) ? 4'h8 : 4'h0);
      chk("R6", "masked wr_stb", wr_stb_o,
          (j == 0) ? 4'ha : (j == 1) ? 4'h7 : (j <= 3) ? 4'hf : 4'h0);
    end

    // R13 single-word write mode
    set_mode(mcode(4, 0, 2, 1));
    for (int j = 0; j <= 4; j++) begin
      cyc(0, j == 0, 0, 0, 0, 0);
      chk("R13", "wr_stb", wr_stb_o, (j == 0) ? 4'hf : 4'h0);
      chk("R13", "col_vld", col_vld_o, j == 0);
    end
    run_burst("R13", 0, 0, 4, 0, 2);

    // R2 reserved codes rejected, length 4 latency 3 kept
    set_mode(mcode(4, 0, 3, 0));
    set_mode({1'b0, 2'b00, 3'b100, 1'b0, 3'b010});
    run_burst("R2", 0, 3, 4, 0, 3);
    set_mode({1'b0, 2'b00, 3'b001, 1'b0, 3'b010});
    run_burst("R2", 0, 3, 4, 0, 3);
    set_mode(mcode(1, 1, 3, 0));
    run_burst("R2", 0, 3, 4, 0, 3);
    set_mode(mcode(256, 1, 3, 0));
    run_burst("R2", 0, 3, 4, 0, 3);
    set_mode({1'b0, 2'b00, 3'b011, 1'b0, 3'b100});
    run_burst("R2", 0, 3, 4, 0, 3);
    set_mode({1'b0, 2'b01, 3'b011, 1'b0, 3'b010});
    run_burst("R2", 0, 3, 4, 0, 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule